// File: doc/BRIEF.md
# Byte-Command SPI Bridge Interpreter

This block sits between a host byte stream (for example the receive and transmit FIFOs of a UART) and an SPI master engine. It reads one command byte at a time, decodes a packed opcode table, updates a small set of control registers that drive chip select, peripheral enables, bus speed and SPI configuration, and sends back one or more response bytes for every command.

The block has three modes. After reset it is in a terminal mode and only watches for a run of zero bytes. That run unlocks a bitbang mode, and from there a further command opens the SPI mode. In SPI mode a byte can go out on the bus in three ways: a bulk command followed by its data bytes, a single nibble command that completes a held byte, or a set of register writes and read-backs. Each exchanged byte returns the byte read from the bus. The SPI shift engine, the sniffer and pin-level bitbanging are outside the block.

Top module: `spi_cmd_bridge`

## Requirements
- R1: After reset the block is in terminal mode (mode_o = 0), cs_o = 1, power, pull-up and AUX enables are 0, speed_o = 0, spi_cfg_o = 4'b0010 and no response byte is pending.
- R2: In terminal mode, ZERO_RUN (default 20) consecutive 0x00 bytes enter bitbang mode (mode_o = 1) and return the five ASCII bytes "BBIO1" (0x42 0x42 0x49 0x4F 0x31). No other terminal-mode byte produces a reply.
- R3: In terminal mode, a non-zero byte received before the run is complete resets the zero count, so a later run must again be complete.
- R4: In bitbang mode, 0x00 repeats "BBIO1", 0x01 enters SPI mode (mode_o = 2) and returns "SPI1" (0x53 0x50 0x49 0x31), and 0x0F returns 0x01 and goes back to terminal mode. In SPI mode, 0x01 repeats "SPI1" and 0x00 returns to bitbang mode with "BBIO1".
- R5: In SPI mode, 0x02 drives cs_o low and 0x03 drives it high. Each returns 0x01.
- R6: In SPI mode, 0x10 to 0x1F return 0x01. The block then takes (low nibble + 1) data bytes, from 1 to 16. Each data byte is exchanged on the SPI port, and the byte read is returned before the next data byte is accepted.
- R7: In SPI mode, 0x3y stores y as the held upper nibble and returns 0x01. 0x2x exchanges {held nibble, x} on SPI and returns the byte read. The held nibble stays in place across exchanges.
- R8: In SPI mode, 0x4w sets {power, pull-up, AUX, CS} from bits 3..0 of w and returns 0x01. 0x50 returns 0x50 | w. Bit 0 of the same register is cs_o.
- R9: In SPI mode, 0x60 to 0x67 set speed_o to bits 2..0 and return 0x01. 0x70 returns 0x70 | speed.
- R10: In SPI mode, 0x8w sets spi_cfg_o to w (bit 3 push-pull output, bit 2 clock idle high, bit 1 clock edge, bit 0 late sample) and returns 0x01. 0x90 returns 0x90 | cfg.
- R11: An opcode outside the table returns 0x00 and changes no register and no mode. Examples are 0x0D, 0x51, 0x68 and 0xA5 in SPI mode, and 0x02 in bitbang mode.
- R12: A response byte holds on tx_data_o until tx_ready_i accepts it. No input byte is taken while a response is pending or an SPI exchange is running. xfer_data_o holds steady until xfer_done_i.
- R13: Data bytes that follow a bulk command are sent on the bus and never decoded as commands. A 0x00 data byte does not leave SPI mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Host byte available |
| rx_data_i | input | 8 | Host byte |
| rx_ready_o | output | 1 | Block takes the host byte this cycle |
| tx_valid_o | output | 1 | Response byte available |
| tx_data_o | output | 8 | Response byte |
| tx_ready_i | input | 1 | Host takes the response byte |
| xfer_req_o | output | 1 | SPI exchange requested, held until done |
| xfer_data_o | output | 8 | Byte to shift out |
| xfer_done_i | input | 1 | SPI exchange finished |
| xfer_data_i | input | 8 | Byte shifted in |
| mode_o | output | 2 | 0 terminal, 1 bitbang, 2 SPI |
| cs_o | output | 1 | Chip select level |
| pwr_en_o | output | 1 | Power supply enable |
| pullup_en_o | output | 1 | Pull-up enable |
| aux_o | output | 1 | Auxiliary pin level |
| speed_o | output | 3 | SPI speed code |
| spi_cfg_o | output | 4 | SPI configuration bits |

## Verification
A wrong mode or zero count shows at the ports on the next command: a missing or extra version string, or an unknown-opcode 0x00 where 0x01 was due. A bad bulk counter shows as a data byte treated as an opcode, or as a hang waiting for a reply, within at most sixteen bytes. A corrupted held nibble or register shows on the next exchanged or read-back byte, because the bench derives every reply byte from the bytes it sent.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NIB_W  = BYTE_W / 2;
  localparam int unsigned MAX_BULK = 16;
  localparam int unsigned BULK_W = $clog2(MAX_BULK) + 1;

  typedef enum logic [1:0] {MODE_TERM = 2'd0, MODE_BB = 2'd1, MODE_SPI = 2'd2} mode_e;
  typedef enum logic [1:0] {RPL_NONE, RPL_BYTE, RPL_BBIO, RPL_SPI} reply_e;
  typedef enum logic [1:0] {ACT_NONE, ACT_NIB, ACT_BULK} act_e;

  typedef struct packed {
    logic              mode_we;
    mode_e             next_mode;
    reply_e            reply;
    logic [BYTE_W-1:0] rbyte;
    act_e              act;
    logic [BULK_W-1:0] bulk_cnt;
    logic              cs_we;
    logic              cs_val;
    logic              per_we;
    logic              spd_we;
    logic              cfg_we;
    logic              hi_we;
    logic              zero_hit;
    logic              zero_miss;
  } dec_t;

  localparam logic [BYTE_W-1:0] ACK  = 8'h01;
  localparam logic [BYTE_W-1:0] NACK = 8'h00;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import bridge_pkg::*;
(
  input  mode_e             mode_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [3:0]        per_i,
  input  logic [2:0]        spd_i,
  input  logic [3:0]        cfg_i,
  output dec_t              dec_o
);
  logic [NIB_W-1:0] op, lo;
  assign op = byte_i[BYTE_W-1:NIB_W];
  assign lo = byte_i[NIB_W-1:0];

  always_comb begin
    dec_o           = '0;
    dec_o.next_mode = mode_i;
    dec_o.reply     = RPL_BYTE;
    dec_o.rbyte     = NACK;
    unique case (mode_i)
      MODE_TERM: begin
        dec_o.reply     = RPL_NONE;
        dec_o.zero_hit  = (byte_i == '0);
        dec_o.zero_miss = (byte_i != '0);
      end
      MODE_BB: begin
        if (byte_i == 8'h00) begin
          dec_o.reply = RPL_BBIO;
        end else if (byte_i == 8'h01) begin
          dec_o.mode_we = 1'b1; dec_o.next_mode = MODE_SPI; dec_o.reply = RPL_SPI;
        end else if (byte_i == 8'h0F) begin
          dec_o.mode_we = 1'b1; dec_o.next_mode = MODE_TERM; dec_o.rbyte = ACK;
        end
      end
      default: begin
        case (op)
          4'h0: begin
            case (lo)
              4'h0: begin dec_o.mode_we = 1'b1; dec_o.next_mode = MODE_BB; dec_o.reply = RPL_BBIO; end
              4'h1: dec_o.reply = RPL_SPI;
              4'h2, 4'h3: begin dec_o.cs_we = 1'b1; dec_o.cs_val = lo[0]; dec_o.rbyte = ACK; end
              default: ;
            endcase
          end
          4'h1: begin
            dec_o.act = ACT_BULK; dec_o.bulk_cnt = BULK_W'(lo) + BULK_W'(1); dec_o.rbyte = ACK;
          end
          4'h2: begin dec_o.act = ACT_NIB; dec_o.reply = RPL_NONE; end
          4'h3: begin dec_o.hi_we = 1'b1; dec_o.rbyte = ACK; end
          4'h4: begin dec_o.per_we = 1'b1; dec_o.rbyte = ACK; end
          4'h5: if (lo == '0) dec_o.rbyte = {op, per_i};
          4'h6: if (!lo[3]) begin dec_o.spd_we = 1'b1; dec_o.rbyte = ACK; end
          4'h7: if (lo == '0) dec_o.rbyte = {op, 1'b0, spd_i};
          4'h8: begin dec_o.cfg_we = 1'b1; dec_o.rbyte = ACK; end
          4'h9: if (lo == '0) dec_o.rbyte = {op, cfg_i};
          default: ;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/zero_run_counter.sv
module zero_run_counter #(
  parameter int unsigned RUN = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic miss_i,
  output logic reached_o
);
  localparam int unsigned CNT_W = (RUN > 1) ? $clog2(RUN) : 1;
  logic [CNT_W-1:0] cnt_q;

  assign reached_o = hit_i && (cnt_q == CNT_W'(RUN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (miss_i || reached_o) cnt_q <= '0;
    else if (hit_i)               cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/reply_seq.sv
module reply_seq
  import bridge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  reply_e            kind_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              pop_i,
  output logic              valid_o,
  output logic              last_o,
  output logic [BYTE_W-1:0] data_o
);
  reply_e            kind_q;
  logic [2:0]        idx_q;
  logic [BYTE_W-1:0] byte_q;

  assign valid_o = (kind_q != RPL_NONE);

  always_comb begin
    last_o = 1'b1;
    data_o = byte_q;
    case (kind_q)
      RPL_BBIO: begin
        last_o = (idx_q == 3'd4);
        case (idx_q)
          3'd0, 3'd1: data_o = 8'h42;
          3'd2:       data_o = 8'h49;
          3'd3:       data_o = 8'h4F;
          default:    data_o = 8'h31;
        endcase
      end
      RPL_SPI: begin
        last_o = (idx_q == 3'd3);
        case (idx_q)
          3'd0:    data_o = 8'h53;
          3'd1:    data_o = 8'h50;
          3'd2:    data_o = 8'h49;
          default: data_o = 8'h31;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= RPL_NONE;
      idx_q  <= '0;
      byte_q <= '0;
    end else if (load_i) begin
      kind_q <= kind_i;
      idx_q  <= '0;
      byte_q <= byte_i;
    end else if (pop_i) begin
      if (last_o) kind_q <= RPL_NONE;
      else        idx_q  <= idx_q + 3'd1;
    end
  end
endmodule

// File: rtl/spi_cmd_bridge.sv
module spi_cmd_bridge
  import bridge_pkg::*;
#(
  parameter int unsigned ZERO_RUN = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  input  logic              tx_ready_i,
  output logic              xfer_req_o,
  output logic [BYTE_W-1:0] xfer_data_o,
  input  logic              xfer_done_i,
  input  logic [BYTE_W-1:0] xfer_data_i,
  output logic [1:0]        mode_o,
  output logic              cs_o,
  output logic              pwr_en_o,
  output logic              pullup_en_o,
  output logic              aux_o,
  output logic [2:0]        speed_o,
  output logic [3:0]        spi_cfg_o
);
  typedef enum logic [1:0] {ST_CMD, ST_BULK, ST_XFER, ST_REPLY} st_e;

  st_e               st_q;
  mode_e             mode_q;
  logic [3:0]        per_q;   // {power, pull-up, aux, cs}
  logic [2:0]        spd_q;
  logic [3:0]        cfg_q;
  logic [NIB_W-1:0]  hi_q;
  logic [BYTE_W-1:0] xd_q;
  logic [BULK_W-1:0] left_q;

  dec_t              dec;
  logic              cmd_acc, bulk_acc, run_done;
  logic              seq_load, seq_valid, seq_last, pop;
  reply_e            seq_kind;
  logic [BYTE_W-1:0] seq_byte;

  assign rx_ready_o = (st_q == ST_CMD) || (st_q == ST_BULK);
  assign cmd_acc    = rx_valid_i && (st_q == ST_CMD);
  assign bulk_acc   = rx_valid_i && (st_q == ST_BULK);
  assign pop        = (st_q == ST_REPLY) && seq_valid && tx_ready_i;

  cmd_decode u_dec (
    .mode_i (mode_q),
    .byte_i (rx_data_i),
    .per_i  (per_q),
    .spd_i  (spd_q),
    .cfg_i  (cfg_q),
    .dec_o  (dec)
  );

  zero_run_counter #(.RUN(ZERO_RUN)) u_zero (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (cmd_acc && dec.zero_hit),
    .miss_i    (cmd_acc && dec.zero_miss),
    .reached_o (run_done)
  );

  always_comb begin
    seq_load = 1'b0;
    seq_kind = RPL_NONE;
    seq_byte = dec.rbyte;
    if ((st_q == ST_XFER) && xfer_done_i) begin
      seq_load = 1'b1;
      seq_kind = RPL_BYTE;
      seq_byte = xfer_data_i;
    end else if (cmd_acc) begin
      if (run_done) begin
        seq_load = 1'b1;
        seq_kind = RPL_BBIO;
      end else if (dec.reply != RPL_NONE) begin
        seq_load = 1'b1;
        seq_kind = dec.reply;
      end
    end
  end

  reply_seq u_rpl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (seq_load),
    .kind_i  (seq_kind),
    .byte_i  (seq_byte),
    .pop_i   (pop),
    .valid_o (seq_valid),
    .last_o  (seq_last),
    .data_o  (tx_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_CMD;
      mode_q <= MODE_TERM;
      per_q  <= 4'b0001;
      spd_q  <= 3'b000;
      cfg_q  <= 4'b0010;
      hi_q   <= '0;
      xd_q   <= '0;
      left_q <= '0;
    end else begin
      case (st_q)
        ST_CMD: if (cmd_acc) begin
          if (dec.mode_we) mode_q <= dec.next_mode;
          if (run_done)    mode_q <= MODE_BB;
          if (dec.cs_we)   per_q[0] <= dec.cs_val;
          if (dec.per_we)  per_q <= rx_data_i[3:0];
          if (dec.spd_we)  spd_q <= rx_data_i[2:0];
          if (dec.cfg_we)  cfg_q <= rx_data_i[3:0];
          if (dec.hi_we)   hi_q  <= rx_data_i[NIB_W-1:0];
          case (dec.act)
            ACT_NIB: begin
              xd_q <= {hi_q, rx_data_i[NIB_W-1:0]};
              st_q <= ST_XFER;
            end
            ACT_BULK: begin
              left_q <= dec.bulk_cnt;
              st_q   <= ST_REPLY;
            end
            default: if (seq_load) st_q <= ST_REPLY;
          endcase
        end
        ST_BULK: if (bulk_acc) begin
          xd_q   <= rx_data_i;
          left_q <= left_q - BULK_W'(1);
          st_q   <= ST_XFER;
        end
        ST_XFER: if (xfer_done_i) st_q <= ST_REPLY;
        default: if (pop && seq_last) st_q <= (left_q != '0) ? ST_BULK : ST_CMD;
      endcase
    end
  end

  assign tx_valid_o  = seq_valid;
  assign xfer_req_o  = (st_q == ST_XFER);
  assign xfer_data_o = xd_q;
  assign mode_o      = mode_q;
  assign pwr_en_o    = per_q[3];
  assign pullup_en_o = per_q[2];
  assign aux_o       = per_q[1];
  assign cs_o        = per_q[0];
  assign speed_o     = spd_q;
  assign spi_cfg_o   = cfg_q;
endmodule

// File: rtl/bridge_checker.sv
module bridge_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_valid_i,
  input logic [3:0] rx_op_i,
  input logic       rx_ready_o,
  input logic       tx_valid_o,
  input logic [7:0] tx_data_o,
  input logic       tx_ready_i,
  input logic       xfer_req_o,
  input logic [7:0] xfer_data_o,
  input logic       xfer_done_i,
  input logic [1:0] mode_o,
  input logic       cs_o,
  input logic [2:0] speed_o,
  input logic [3:0] spi_cfg_o
);
  a_r12_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  a_r12_xfer_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o && !xfer_done_i |=> xfer_req_o && $stable(xfer_data_o));

  a_r12_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> !tx_valid_o && !xfer_req_o);

  a_r5_cs_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cs_o) |-> $past(rx_valid_i && rx_ready_o));

  a_r4_spi_from_bb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2) && ($past(mode_o) != 2'd2) |-> $past(mode_o) == 2'd1);

  a_r9_speed_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(speed_o) |-> $past(rx_valid_i && rx_ready_o && rx_op_i == 4'h6));

  a_r10_cfg_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(spi_cfg_o) |-> $past(rx_valid_i && rx_ready_o && rx_op_i == 4'h8));
endmodule

bind spi_cmd_bridge bridge_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_valid_i  (rx_valid_i),
  .rx_op_i     (rx_data_i[7:4]),
  .rx_ready_o  (rx_ready_o),
  .tx_valid_o  (tx_valid_o),
  .tx_data_o   (tx_data_o),
  .tx_ready_i  (tx_ready_i),
  .xfer_req_o  (xfer_req_o),
  .xfer_data_o (xfer_data_o),
  .xfer_done_i (xfer_done_i),
  .mode_o      (mode_o),
  .cs_o        (cs_o),
  .speed_o     (speed_o),
  .spi_cfg_o   (spi_cfg_o)
);

// File: tb/sim_spi_cmd_bridge.sv
module sim_spi_cmd_bridge;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] RD_MASK = 8'hA5;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       rx_ready_o, tx_valid_o;
  logic [7:0] tx_data_o;
  logic       tx_ready_i = 1'b1;
  logic       xfer_req_o;
  logic [7:0] xfer_data_o;
  logic       xfer_done_i = 1'b0;
  logic [7:0] xfer_data_i = '0;
  logic [1:0] mode_o;
  logic       cs_o, pwr_en_o, pullup_en_o, aux_o;
  logic [2:0] speed_o;
  logic [3:0] spi_cfg_o;

  spi_cmd_bridge u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .rx_ready_o(rx_ready_o),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i),
    .xfer_req_o(xfer_req_o), .xfer_data_o(xfer_data_o),
    .xfer_done_i(xfer_done_i), .xfer_data_i(xfer_data_i),
    .mode_o(mode_o), .cs_o(cs_o), .pwr_en_o(pwr_en_o), .pullup_en_o(pullup_en_o),
    .aux_o(aux_o), .speed_o(speed_o), .spi_cfg_o(spi_cfg_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int         n_cmp = 0;
  int         n_bad = 0;
  int         cyc = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_b(input string tag, input logic [7:0] b);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  task automatic expect_bbio(input string tag);
    expect_b(tag, 8'h42); expect_b(tag, 8'h42); expect_b(tag, 8'h49);
    expect_b(tag, 8'h4F); expect_b(tag, 8'h31);
  endtask

  task automatic expect_spi(input string tag);
    expect_b(tag, 8'h53); expect_b(tag, 8'h50); expect_b(tag, 8'h49); expect_b(tag, 8'h31);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Monitor: handshake values seen at negedge hold through the next posedge
  always @(negedge clk) begin
    if (rst_ni && tx_valid_o && tx_ready_i) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R12 unexpected reply: actual %0h expected none", tx_data_o);
      end else begin
        check(tag_q.pop_front(), tx_data_o, exp_q.pop_front());
      end
    end
  end

  // Host back-pressure pattern
  always @(posedge clk) begin
    #1;
    cyc++;
    tx_ready_i = (cyc % 4) != 1;
  end

  // SPI engine model: returns sent byte xor mask after a few cycles
  initial begin
    logic [7:0] sent;
    forever begin
      @(negedge clk);
      if (rst_ni && xfer_req_o) begin
        sent = xfer_data_o;
        repeat (2) @(negedge clk);
        @(posedge clk); #1;
        xfer_done_i = 1'b1;
        xfer_data_i = sent ^ RD_MASK;
        @(posedge clk); #1;
        xfer_done_i = 1'b0;
      end
    end
  end

  task automatic send(input logic [7:0] b);
    @(posedge clk); #1;
    rx_valid_i = 1'b1;
    rx_data_i  = b;
    forever begin
      @(negedge clk);
      if (rx_ready_o) break;
    end
    @(posedge clk); #1;
    rx_valid_i = 1'b0;
  endtask

  task automatic drain();
    forever begin
      @(negedge clk);
      if (exp_q.size() == 0 && rx_ready_o) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic xchg(input string tag, input logic [7:0] b);
    expect_b(tag, b ^ RD_MASK);
    send(b);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL R12 watchdog expired: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 mode", mode_o, 2'd0);
    check("R1 cs", cs_o, 1'b1);
    check("R1 periph", {pwr_en_o, pullup_en_o, aux_o}, 3'b000);
    check("R1 speed", speed_o, 3'd0);
    check("R1 cfg", spi_cfg_o, 4'b0010);
    check("R1 tx idle", tx_valid_o, 1'b0);

    // R3: broken run does not count
    for (int i = 0; i < 19; i++) send(8'h00);
    send(8'h41);
    for (int i = 0; i < 19; i++) send(8'h00);
    drain();
    check("R3 still terminal", mode_o, 2'd0);
    // R2: twentieth zero after the break
    expect_bbio("R2 entry string");
    send(8'h00);
    drain();
    check("R2 bitbang mode", mode_o, 2'd1);

    // R11 in bitbang: CS command unknown
    expect_b("R11 bitbang 0x02", 8'h00); send(8'h02);
    drain();
    check("R11 cs unchanged", cs_o, 1'b1);
    // R4 transitions
    expect_bbio("R4 bitbang repeat"); send(8'h00);
    expect_spi("R4 spi entry"); send(8'h01);
    drain();
    check("R4 spi mode", mode_o, 2'd2);
    expect_spi("R4 spi repeat"); send(8'h01);

    // R5 chip select
    expect_b("R5 cs low ack", 8'h01); send(8'h02);
    drain();
    check("R5 cs low", cs_o, 1'b0);
    expect_b("R5 cs high ack", 8'h01); send(8'h03);
    drain();
    check("R5 cs high", cs_o, 1'b1);

    // R6 / R13 bulk of three, including a zero data byte
    expect_b("R6 bulk ack", 8'h01); send(8'h12);
    xchg("R13 zero data", 8'h00);
    xchg("R6 bulk data", 8'h3C);
    xchg("R6 bulk data", 8'hFF);
    drain();
    check("R13 still spi", mode_o, 2'd2);
    // R6 single-byte bulk
    expect_b("R6 bulk1 ack", 8'h01); send(8'h10);
    xchg("R6 bulk1 data", 8'h81);
    drain();

    // R7 nibbles
    expect_b("R7 high ack", 8'h01); send(8'h3C);
    expect_b("R7 exchange", 8'hC5 ^ RD_MASK); send(8'h25);
    expect_b("R7 persist", 8'hCA ^ RD_MASK); send(8'h2A);
    drain();

    // R8 peripherals
    expect_b("R8 set ack", 8'h01); send(8'h4B);
    drain();
    check("R8 pins", {pwr_en_o, pullup_en_o, aux_o, cs_o}, 4'b1011);
    expect_b("R8 readback", 8'h5B); send(8'h50);
    expect_b("R8 set ack", 8'h01); send(8'h44);
    drain();
    check("R8 pins", {pwr_en_o, pullup_en_o, aux_o, cs_o}, 4'b0100);
    expect_b("R8 readback", 8'h54); send(8'h50);

    // R9 speed
    expect_b("R9 set ack", 8'h01); send(8'h65);
    drain();
    check("R9 speed", speed_o, 3'd5);
    expect_b("R9 readback", 8'h75); send(8'h70);
    expect_b("R11 0x68", 8'h00); send(8'h68);
    drain();
    check("R11 speed kept", speed_o, 3'd5);

    // R10 config
    expect_b("R10 set ack", 8'h01); send(8'h8D);
    drain();
    check("R10 cfg", spi_cfg_o, 4'b1101);
    expect_b("R10 readback", 8'h9D); send(8'h90);

    // R11 unknown opcodes
    expect_b("R11 0x0D", 8'h00); send(8'h0D);
    expect_b("R11 0xA5", 8'h00); send(8'hA5);
    expect_b("R11 0x51", 8'h00); send(8'h51);
    drain();
    check("R11 regs kept", {pwr_en_o, pullup_en_o, aux_o, cs_o, spi_cfg_o}, 8'b0100_1101);
    check("R11 mode kept", mode_o, 2'd2);

    // R6 maximum bulk of sixteen
    expect_b("R6 bulk16 ack", 8'h01); send(8'h1F);
    for (int i = 0; i < 16; i++) xchg("R6 bulk16 data", 8'(i * 17));
    drain();
    check("R6 after bulk16 mode", mode_o, 2'd2);

    // R4 leave SPI and bitbang
    expect_bbio("R4 spi exit"); send(8'h00);
    drain();
    check("R4 bitbang mode", mode_o, 2'd1);
    expect_b("R4 reset ack", 8'h01); send(8'h0F);
    drain();
    check("R4 terminal mode", mode_o, 2'd0);
    // R2: single zero in fresh terminal mode is silent
    send(8'h00);
    drain();
    check("R2 no reply", tx_valid_o, 1'b0);
    check("R2 mode", mode_o, 2'd0);
    check("R12 queue empty", exp_q.size(), 0);

    finish_run();
  end
endmodule